// File: doc/BRIEF.md
# Pin mode configuration bank

This block holds the operating mode of a group of multiplexed digital pins. Each pin is either handed to its peripheral function block, forced low, forced high, or released to high impedance so that it serves as an input. A pin that its peripheral does not need can therefore act as general-purpose I/O: software forces it high or low, or releases it and reads it.

The mode of each pin is two bits, held in two bit-planes, one word with one bit per pin. Software never rewrites a plane. It changes bits through a set address and a clear address for each plane. A 1 in the written word acts on that pin, and a 0 leaves that pin alone, so two drivers of different pins never have to read, modify and write back. A separate read address returns the live pin levels after a synchronizer. The levels can be read in any mode.

The bus is a simple single-request register port. A write takes effect at the clock edge where it is presented. Read data is registered and appears one cycle after the request. The pad cells themselves sit outside the block. The block produces only the output value and the output enable for each pad.

Top module: `pincfg_bank`

## Requirements
- R1: While reset is asserted, and after reset until the first write, every mode bit is 0, every pin is in high-impedance mode (pad_oe and pad_out low), and the plane reads return 0.
- R2: A pin with m1m0 = 01 passes func_out to pad_out and func_oe to pad_oe for that pin.
- R3: A pin with m1m0 = 10 drives pad_oe = 1 and pad_out = 0, whatever func_out and func_oe are.
- R4: A pin with m1m0 = 11 drives pad_oe = 1 and pad_out = 1, whatever func_out and func_oe are.
- R5: A pin with m1m0 = 00 drives pad_oe = 0 and pad_out = 0, whatever func_out and func_oe are.
- R6: A write to the m0 set address (word address 1) or the m1 set address (5) sets every plane bit whose wdata bit is 1 and leaves the bits written with 0 unchanged. Bit i of wdata is pin i. wdata bits at or above NUM_PINS are ignored.
- R7: A write to the m0 clear address (2) or the m1 clear address (6) clears every plane bit whose wdata bit is 1 and leaves the bits written with 0 unchanged.
- R8: A read request at addresses 0, 1 or 2 returns the m0 plane, and a read at 4, 5 or 6 returns the m1 plane. Bit i is pin i, and the bits at and above NUM_PINS are zero. bus_rdata holds the value from the clock edge after the request until the next read.
- R9: A read at address 8 returns the pad_in levels through a SYNC_STAGES-flop synchronizer, in every mode. With the default of 2, a level that is driven before edge k is returned by a read requested at edge k+2 but not by one requested at edge k+1.
- R10: Writes to addresses 0, 3, 4, 7, 8 and every other address outside {1, 2, 5, 6} change no mode bit. Reads of addresses outside {0, 1, 2, 4, 5, 6, 8} return 0.
- R11: Writes to the same bit issued on consecutive cycles take effect in order. Set then clear leaves the bit 0, and clear then set leaves it 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data, bit i = pin i |
| bus_rdata | output | DATA_W | Registered read data |
| func_out | input | NUM_PINS | Output value from the peripheral functions |
| func_oe | input | NUM_PINS | Output enable from the peripheral functions |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Output value to the pads |
| pad_oe | output | NUM_PINS | Output enable to the pads |

## Verification
The bench sweeps every pin of an eight-pin bank through all four modes, with every combination of the function signals, and checks all pins each time. A pad decode that swapped the two forced modes, or let the function enable leak into a forced or released pin, shows up at once in that sweep. Set and clear words are chosen so that 0 bits sit next to 1 bits, and some words carry ones above the pin count. Writes to read-only and unmapped addresses are included. A design that wrote the whole word, used the clear address as a plain store, or decoded addresses loosely would change bits that should keep their value. The synchronizer is checked for its exact latency, once with one idle cycle before the read and once with two. Back-to-back set and clear of the same bit exposes a design that reorders or merges writes.

// File: rtl/pincfg_pkg.sv
package pincfg_pkg;

   // Pin operating modes, {m1,m0}
   typedef enum logic [1:0] {
      PM_HIZ  = 2'b00,
      PM_FUNC = 2'b01,
      PM_LOW  = 2'b10,
      PM_HIGH = 2'b11
   } pin_mode_e;

   // Word offsets of the register window
   localparam int unsigned OFS_M0_RD  = 0;
   localparam int unsigned OFS_M0_SET = 1;
   localparam int unsigned OFS_M0_CLR = 2;
   localparam int unsigned OFS_M1_RD  = 4;
   localparam int unsigned OFS_M1_SET = 5;
   localparam int unsigned OFS_M1_CLR = 6;
   localparam int unsigned OFS_LEVEL  = 8;
   localparam int unsigned MIN_ADDR_W = 4;

   typedef struct packed {
      logic m0_rd;
      logic m0_set;
      logic m0_clr;
      logic m1_rd;
      logic m1_set;
      logic m1_clr;
      logic level;
   } reg_hit_t;

endpackage

// File: rtl/pincfg_plane.sv
module pincfg_plane #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic             clr_en,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] bits_q
);

   // One bit-plane: set and clear come from distinct addresses, never together
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bits_q <= '0;
      else if (set_en)
         bits_q <= bits_q | mask;
      else if (clr_en)
         bits_q <= bits_q & ~mask;
   end

endmodule

// File: rtl/pincfg_sync.sv
module pincfg_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q[0] <= din;
         for (int s = 1; s < STAGES; s++)
            stg_q[s] <= stg_q[s-1];
      end
   end

   assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/pincfg_padmux.sv
module pincfg_padmux
   import pincfg_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] m0,
   input  logic [WIDTH-1:0] m1,
   input  logic [WIDTH-1:0] func_out,
   input  logic [WIDTH-1:0] func_oe,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      pin_mode_e mode;
      logic      po;
      logic      poe;

      assign mode = pin_mode_e'({m1[i], m0[i]});

      always_comb begin
         case (mode)
            PM_FUNC: begin po = func_out[i]; poe = func_oe[i]; end
            PM_LOW:  begin po = 1'b0;        poe = 1'b1;       end
            PM_HIGH: begin po = 1'b1;        poe = 1'b1;       end
            default: begin po = 1'b0;        poe = 1'b0;       end
         endcase
      end

      assign pad_out[i] = po;
      assign pad_oe[i]  = poe;
   end

endmodule

// File: rtl/pincfg_decode.sv
module pincfg_decode
   import pincfg_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_hit_t          hit
);

   always_comb begin
      hit.m0_rd  = (addr == ADDR_W'(OFS_M0_RD));
      hit.m0_set = (addr == ADDR_W'(OFS_M0_SET));
      hit.m0_clr = (addr == ADDR_W'(OFS_M0_CLR));
      hit.m1_rd  = (addr == ADDR_W'(OFS_M1_RD));
      hit.m1_set = (addr == ADDR_W'(OFS_M1_SET));
      hit.m1_clr = (addr == ADDR_W'(OFS_M1_CLR));
      hit.level  = (addr == ADDR_W'(OFS_LEVEL));
   end

endmodule

// File: rtl/pincfg_rdmux.sv
module pincfg_rdmux
   import pincfg_pkg::*;
#(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  reg_hit_t          hit,
   input  logic [WIDTH-1:0]  m0,
   input  logic [WIDTH-1:0]  m1,
   input  logic [WIDTH-1:0]  level,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] rd_nxt;

   always_comb begin
      rd_nxt = '0;
      if (hit.m0_rd || hit.m0_set || hit.m0_clr)
         rd_nxt = DATA_W'(m0);
      else if (hit.m1_rd || hit.m1_set || hit.m1_clr)
         rd_nxt = DATA_W'(m1);
      else if (hit.level)
         rd_nxt = DATA_W'(level);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_en)
         rdata <= rd_nxt;
   end

endmodule

// File: rtl/pincfg_bank.sv
module pincfg_bank
   import pincfg_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_valid,
   input  logic                bus_write,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] func_out,
   input  logic [NUM_PINS-1:0] func_oe,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe
);

   localparam int unsigned NUM_PLANES = 2;

   // Elaboration-time parameter checks
   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("pincfg_bank: NUM_PINS must lie in 1..DATA_W");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("pincfg_bank: ADDR_W too narrow for the register window");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("pincfg_bank: SYNC_STAGES must be 2 or 3");
   end

   reg_hit_t                            hit;
   logic                                wr_req;
   logic                                rd_req;
   logic [NUM_PINS-1:0]                 wmask;
   logic [NUM_PLANES-1:0]               set_sel;
   logic [NUM_PLANES-1:0]               clr_sel;
   logic [NUM_PLANES-1:0][NUM_PINS-1:0] plane;
   logic [NUM_PINS-1:0]                 plane_m0;
   logic [NUM_PINS-1:0]                 plane_m1;
   logic [NUM_PINS-1:0]                 level_sync;
   logic                                unused_wdata;

   assign wr_req       = bus_valid &  bus_write;
   assign rd_req       = bus_valid & ~bus_write;
   assign wmask        = bus_wdata[NUM_PINS-1:0];
   assign unused_wdata = ^bus_wdata;

   pincfg_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr (bus_addr),
      .hit  (hit)
   );

   assign set_sel = {hit.m1_set, hit.m0_set};
   assign clr_sel = {hit.m1_clr, hit.m0_clr};

   for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
      pincfg_plane #(.WIDTH(NUM_PINS)) u_plane (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_en (wr_req & set_sel[p]),
         .clr_en (wr_req & clr_sel[p]),
         .mask   (wmask),
         .bits_q (plane[p])
      );
   end

   assign plane_m0 = plane[0];
   assign plane_m1 = plane[1];

   pincfg_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pad_in),
      .dout  (level_sync)
   );

   pincfg_padmux #(.WIDTH(NUM_PINS)) u_padmux (
      .m0       (plane_m0),
      .m1       (plane_m1),
      .func_out (func_out),
      .func_oe  (func_oe),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe)
   );

   pincfg_rdmux #(.WIDTH(NUM_PINS), .DATA_W(DATA_W)) u_rdmux (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_en (rd_req),
      .hit   (hit),
      .m0    (plane_m0),
      .m1    (plane_m1),
      .level (level_sync),
      .rdata (bus_rdata)
   );

endmodule

// File: rtl/pincfg_bank_chk.sv
module pincfg_bank_chk
   import pincfg_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_valid,
   input logic                bus_write,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [NUM_PINS-1:0] func_out,
   input logic [NUM_PINS-1:0] func_oe,
   input logic [NUM_PINS-1:0] pad_in,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] m0_q,
   input logic [NUM_PINS-1:0] m1_q
);

   logic [2:0]          cyc;
   logic [NUM_PINS-1:0] wd;
   logic                wr_m0_set;
   logic                wr_m1_clr;
   logic                wr_other;
   logic                rd_m0;
   logic                rd_level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cyc <= '0;
      else if (cyc != 3'd7)
         cyc <= cyc + 3'd1;
   end

   assign wd        = bus_wdata[NUM_PINS-1:0];
   assign wr_m0_set = bus_valid && bus_write && bus_addr == ADDR_W'(1);
   assign wr_m1_clr = bus_valid && bus_write && bus_addr == ADDR_W'(6);
   assign wr_other  = bus_valid && bus_write && bus_addr != ADDR_W'(1) && bus_addr != ADDR_W'(2)
                      && bus_addr != ADDR_W'(5) && bus_addr != ADDR_W'(6);
   assign rd_m0     = bus_valid && !bus_write && bus_addr == ADDR_W'(0);
   assign rd_level  = bus_valid && !bus_write && bus_addr == ADDR_W'(8);

   // R1
   reset_hiz_chk: assert property (@(posedge clk) !rst_n |-> (pad_oe == '0 && m0_q == '0 && m1_q == '0));

   // R6
   set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_m0_set |=> ((m0_q & $past(wd)) == $past(wd)) && ((m0_q & ~$past(wd)) == ($past(m0_q) & ~$past(wd))));

   // R7
   clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_m1_clr |=> ((m1_q & $past(wd)) == '0) && ((m1_q & ~$past(wd)) == ($past(m1_q) & ~$past(wd))));

   // R10
   no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_other |=> $stable(m0_q) && $stable(m1_q));

   // R8
   plane_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_m0 |=> bus_rdata == DATA_W'($past(m0_q)));

   // R9
   if (SYNC_STAGES == 2) begin : g_lvl2
      level_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_level && cyc >= 3'd5) |=> bus_rdata == DATA_W'($past(pad_in, 3)));
   end else begin : g_lvl3
      level_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_level && cyc >= 3'd6) |=> bus_rdata == DATA_W'($past(pad_in, 4)));
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
      // R3 R4
      forced_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
         m1_q[i] |-> (pad_oe[i] && pad_out[i] == m0_q[i]));
      // R2
      func_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!m1_q[i] && m0_q[i]) |-> (pad_oe[i] == func_oe[i] && pad_out[i] == func_out[i]));
      // R5
      released_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!m1_q[i] && !m0_q[i]) |-> (!pad_oe[i] && !pad_out[i]));
   end

endmodule

bind pincfg_bank pincfg_bank_chk #(
   .NUM_PINS    (NUM_PINS),
   .DATA_W      (DATA_W),
   .ADDR_W      (ADDR_W),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .func_out  (func_out),
   .func_oe   (func_oe),
   .pad_in    (pad_in),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .m0_q      (plane_m0),
   .m1_q      (plane_m1)
);

// File: tb/pincfg_bank_tb.sv
module pincfg_bank_tb;

   localparam int NP = 8;
   localparam int DW = 32;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0;
   logic          bus_write = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [NP-1:0] func_out = '0;
   logic [NP-1:0] func_oe = '0;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out;
   logic [NP-1:0] pad_oe;

   int checks = 0;
   int errors = 0;
   logic [NP-1:0] mdl_m0 = '0;
   logic [NP-1:0] mdl_m1 = '0;
   logic [DW-1:0] rd;

   always #10 clk = ~clk;   // 50 MHz

   pincfg_bank #(.NUM_PINS(NP), .DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .func_out(func_out), .func_oe(func_oe), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic bus_wr(input int a, input logic [DW-1:0] d);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      // model: R6 set, R7 clear, R10 others ignored
      case (a)
         1: mdl_m0 = mdl_m0 | d[NP-1:0];
         2: mdl_m0 = mdl_m0 & ~d[NP-1:0];
         5: mdl_m1 = mdl_m1 | d[NP-1:0];
         6: mdl_m1 = mdl_m1 & ~d[NP-1:0];
         default: ;
      endcase
   endtask

   task automatic bus_rd(input int a, output logic [DW-1:0] d);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(a);
      @(negedge clk);
      bus_valid = 1'b0;
      d = bus_rdata;
   endtask

   task automatic set_mode(input int pin, input int mode);
      logic [DW-1:0] m;
      m = DW'(1) << pin;
      bus_wr((mode & 1) != 0 ? 1 : 2, m);
      bus_wr((mode & 2) != 0 ? 5 : 6, m);
   endtask

   task automatic check_pads();
      for (int i = 0; i < NP; i++) begin
         int  md;
         logic eo, ee;
         md = {mdl_m1[i], mdl_m0[i]};
         case (md)
            1: begin eo = func_out[i]; ee = func_oe[i]; chk("R2 func pin", DW'({pad_oe[i], pad_out[i]}), DW'({ee, eo})); end
            2: begin chk("R3 low pin",  DW'({pad_oe[i], pad_out[i]}), DW'(2'b10)); end
            3: begin chk("R4 high pin", DW'({pad_oe[i], pad_out[i]}), DW'(2'b11)); end
            default: begin chk("R5 hiz pin", DW'({pad_oe[i], pad_out[i]}), DW'(2'b00)); end
         endcase
      end
   endtask

   task automatic check_planes(input string req);
      bus_rd(0, rd); chk(req, rd, DW'(mdl_m0));
      bus_rd(4, rd); chk(req, rd, DW'(mdl_m1));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      func_out = 8'hFF; func_oe = 8'hFF;
      repeat (2) @(negedge clk);
      // R1: in reset
      chk("R1 oe in reset", DW'(pad_oe), '0);
      chk("R1 out in reset", DW'(pad_out), '0);
      rst_n = 1'b1;
      @(negedge clk);
      check_planes("R1 planes after reset");
      chk("R1 oe after reset", DW'(pad_oe), '0);

      // R2..R5: sweep every pin through every mode with every function pattern
      for (int p = 0; p < NP; p++) begin
         for (int md = 0; md < 4; md++) begin
            set_mode(p, md);
            for (int f = 0; f < 4; f++) begin
               func_out = (f & 1) != 0 ? 8'hA5 : 8'h5A;
               func_oe  = (f & 2) != 0 ? 8'h3C : 8'hC3;
               #1;
               check_pads();
            end
         end
         set_mode(p, p % 4);   // leave a mix behind
      end
      check_planes("R8 plane read mixed");

      // R6: set with 0 bits beside 1 bits and ones above NUM_PINS
      bus_wr(2, 32'hFF); bus_wr(6, 32'hFF);
      bus_wr(1, 32'hFFFF_FF00);
      check_planes("R6 upper bits ignored");
      bus_wr(1, 32'h0000_00A5);
      bus_rd(0, rd); chk("R6 m0 set", rd, 32'h0000_00A5);
      bus_wr(1, 32'h0000_0012);
      bus_rd(0, rd); chk("R6 m0 set keeps zeros", rd, 32'h0000_00B7);
      bus_wr(5, 32'h0000_0081);
      bus_rd(4, rd); chk("R6 m1 set", rd, 32'h0000_0081);
      bus_rd(5, rd); chk("R8 read at set addr", rd, 32'h0000_0081);
      bus_rd(1, rd); chk("R8 read at m0 set addr", rd, 32'h0000_00B7);

      // R7: clear
      bus_wr(2, 32'h0000_000F);
      bus_rd(2, rd); chk("R7 m0 clear", rd, 32'h0000_00B0);
      bus_wr(5, 32'hFF); bus_wr(6, 32'h0000_0042);
      bus_rd(6, rd); chk("R7 m1 clear", rd, 32'h0000_00BD);
      check_pads();

      // R8: full plane read has upper bits zero
      bus_wr(1, 32'hFFFF_FFFF);
      bus_rd(0, rd); chk("R8 upper bits zero", rd, 32'h0000_00FF);

      // R10: writes to read-only and unmapped addresses; unmapped reads
      for (int a = 0; a < 16; a++) begin
         if (a != 1 && a != 2 && a != 5 && a != 6) begin
            bus_wr(a, 32'h0000_0000);
            bus_wr(a, 32'hFFFF_FFFF);
         end
      end
      check_planes("R10 stray writes ignored");
      check_pads();
      for (int a = 0; a < 16; a++) begin
         if (a == 3 || a == 7 || a > 8) begin
            bus_rd(a, rd); chk("R10 unmapped read zero", rd, '0);
         end
      end

      // R11: consecutive-cycle set then clear, clear then set
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(5); bus_wdata = 32'h10;
      @(negedge clk);
      bus_addr = AW'(6);
      @(negedge clk);
      bus_addr = AW'(2); bus_wdata = 32'h04;
      @(negedge clk);
      bus_addr = AW'(1);
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      mdl_m1 = mdl_m1 & ~8'h10;
      bus_rd(4, rd); chk("R11 set then clear", rd, DW'(mdl_m1));
      bus_rd(0, rd); chk("R11 clear then set", rd, DW'(mdl_m0));

      // R9: level read in each mode, exact synchronizer latency
      for (int md = 0; md < 4; md++) begin
         for (int p = 0; p < NP; p++) set_mode(p, md);
         for (int k = 0; k < 4; k++) begin
            logic [NP-1:0] old_lvl, new_lvl;
            old_lvl = pad_in;
            new_lvl = NP'((md * 64 + k * 37 + 11) ^ 8'h5C);
            if (new_lvl == old_lvl) new_lvl = ~old_lvl;
            pad_in = new_lvl;
            @(negedge clk);
            bus_rd(8, rd); chk("R9 level not yet through sync", rd, DW'(old_lvl));
            bus_rd(8, rd); chk("R9 level after sync", rd, DW'(new_lvl));
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule